// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Estimator

This block produces a coarse reciprocal estimate of a floating-point operand by working on the exponent field only. The operand can be half, single or double precision. The sign is kept and the fraction is cleared. The exponent becomes its bitwise complement. An operand with a zero exponent field maps to the largest finite exponent instead. NaN operands follow their own rules: a signalling NaN is quietened and flagged, and an optional mode replaces every NaN with a canonical default NaN. An optional flush control treats input denormals as signed zeros and reports that it did so.

Each valid operand takes one registered pipeline stage. An operand is presented with a valid strobe and a format code. The result, the invalid-operation flag and the input-denormal flag appear together with a valid strobe one clock later.

Top module: `fp_recip_exp`

## Requirements
- R1: `res_vld` is high in exactly the cycle after a cycle in which `op_vld` was high. While `rst` is asserted and after it, all outputs are zero until the first valid result.
- R2: For a finite operand whose exponent field e is nonzero, the result has the operand's sign, exponent field (2^E-1)-e (the bitwise inverse of e), and an all-zero fraction. The invalid flag is 0.
- R3: For an operand whose exponent field is zero (a signed zero, or a denormal when flushing is off), the result has the operand's sign, exponent field 2^E-2 (all ones except the LSB), and a zero fraction.
- R4: With `flush_en`=1 a denormal operand gives the R3 result and raises `denorm_flag`. With `flush_en`=0, or for any non-denormal operand, `denorm_flag` is 0.
- R5: A signalling NaN (exponent all ones, fraction nonzero, fraction MSB 0) raises `invalid`. With `dnan_en`=0 the result is the operand with its fraction MSB set.
- R6: A quiet NaN (exponent all ones, fraction MSB 1) with `dnan_en`=0 passes through unchanged, and `invalid` stays 0.
- R7: With `dnan_en`=1 any NaN returns the default NaN: sign 0, exponent all ones, and a fraction with only its MSB set. A signalling NaN still raises `invalid`.
- R8: An infinity gives a zero of the same sign, with `invalid` at 0.
- R9: `fmt` selects half (0), single (1) or double (2). Code 3 acts as double. The formats use bits 15:0 (exponent 14:10), 31:0 (exponent 30:23) and 63:0 (exponent 62:52). Operand bits above the format width are ignored, and the matching result bits are zero.
- R10: `invalid` and `denorm_flag` are 0 in every cycle in which `res_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Operand valid strobe |
| op_data | input | 64 | Operand, right-aligned for the chosen format |
| fmt | input | 2 | Format code: 0 half, 1 single, 2 or 3 double |
| flush_en | input | 1 | Treat input denormals as zeros |
| dnan_en | input | 1 | Replace every NaN result with the default NaN |
| res_vld | output | 1 | Result valid, one cycle after `op_vld` |
| res_data | output | 64 | Result, right-aligned, upper bits zero |
| invalid | output | 1 | Signalling NaN operand seen |
| denorm_flag | output | 1 | Input denormal was flushed |

## Verification
Every format is swept with nine operand classes:
- zero;
- the smallest and largest denormal;
- the smallest, a middle and the largest normal exponent;
- infinity;
- quiet NaN;
- signalling NaN.

Each class is run with both signs and all four combinations of flush and default-NaN mode.

The sweep separates the pure exponent inversion from the zero-exponent substitute. Running denormals with flushing on and off shows that only the flag changes, not the value. The NaN classes in both modes separate pass-through, quietening and default-NaN substitution. Garbage above the format width and format code 3 test the field selection.

// File: rtl/fre_pkg.sv
package fre_pkg;
  localparam int NUM_FMT = 3;
  localparam int DATA_W  = 64;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_ALT_DB = 2'd3
  } fre_fmt_e;

  function automatic int exp_w(input int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int frac_w(input int idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic int fmt_index(input fre_fmt_e f);
    case (f)
      FMT_HALF:   return 0;
      FMT_SINGLE: return 1;
      default:    return 2;
    endcase
  endfunction
endpackage

// File: rtl/fre_lane.sv
module fre_lane #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] x,
  input  logic                  flush_en,
  input  logic                  dnan_en,
  output logic [EXP_W+FRAC_W:0] r,
  output logic                  inv,
  output logic                  den
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_zero, ex_ones, fr_zero, is_nan, is_snan;
  logic [EXP_W-1:0]  ex_out;

  assign sgn     = x[W-1];
  assign ex      = x[W-2:FRAC_W];
  assign fr      = x[FRAC_W-1:0];
  assign ex_zero = (ex == '0);
  assign ex_ones = (ex == '1);
  assign fr_zero = (fr == '0);
  assign is_nan  = ex_ones && !fr_zero;
  assign is_snan = is_nan && !fr[FRAC_W-1];

  always_comb begin
    ex_out = ex_zero ? {{(EXP_W-1){1'b1}}, 1'b0} : ~ex;
    den    = 1'b0;
    inv    = is_snan;
    if (is_nan) begin
      if (dnan_en) r = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      else         r = {sgn, ex, 1'b1, fr[FRAC_W-2:0]};
    end else begin
      den = flush_en && ex_zero && !fr_zero;
      r   = {sgn, ex_out, {FRAC_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fre_stage.sv
module fre_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_res,
  input  logic              in_inv,
  input  logic              in_den,
  input  logic [1:0]        in_fmt,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_res,
  output logic              out_inv,
  output logic              out_den,
  output logic [1:0]        out_fmt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_res <= '0;
      out_inv <= 1'b0;
      out_den <= 1'b0;
      out_fmt <= 2'd0;
    end else begin
      out_vld <= in_vld;
      out_inv <= in_vld && in_inv;
      out_den <= in_vld && in_den;
      if (in_vld) begin
        out_res <= in_res;
        out_fmt <= in_fmt;
      end
    end
  end
endmodule

// File: rtl/fp_recip_exp.sv
module fp_recip_exp
  import fre_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        op_vld,
  input  logic [63:0] op_data,
  input  logic [1:0]  fmt,
  input  logic        flush_en,
  input  logic        dnan_en,
  output logic        res_vld,
  output logic [63:0] res_data,
  output logic        invalid,
  output logic        denorm_flag
);
  logic [DATA_W-1:0] lane_res [NUM_FMT];
  logic [NUM_FMT-1:0] lane_inv, lane_den;
  int                 sel;
  logic [DATA_W-1:0]  sel_res;
  logic               sel_inv, sel_den;
  logic [1:0]         fmt_q;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int E = exp_w(g);
    localparam int F = frac_w(g);
    localparam int W = E + F + 1;
    logic [W-1:0] r_g;
    fre_lane #(.EXP_W(E), .FRAC_W(F)) u_lane (
      .x(op_data[W-1:0]), .flush_en(flush_en), .dnan_en(dnan_en),
      .r(r_g), .inv(lane_inv[g]), .den(lane_den[g])
    );
    if (W < DATA_W) begin : g_pad
      assign lane_res[g] = {{(DATA_W-W){1'b0}}, r_g};
    end else begin : g_full
      assign lane_res[g] = r_g;
    end
  end

  always_comb begin
    sel     = fmt_index(fre_fmt_e'(fmt));
    sel_res = lane_res[sel];
    sel_inv = lane_inv[sel];
    sel_den = lane_den[sel];
  end

  fre_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst),
    .in_vld(op_vld), .in_res(sel_res), .in_inv(sel_inv), .in_den(sel_den), .in_fmt(fmt),
    .out_vld(res_vld), .out_res(res_data), .out_inv(invalid), .out_den(denorm_flag),
    .out_fmt(fmt_q)
  );

  AST_LATENCY_HI: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> res_vld); // R1
  AST_LATENCY_LO: assert property (@(posedge clk) disable iff (rst)
    !op_vld |=> !res_vld); // R1
  AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> (!invalid && !denorm_flag)); // R10
  AST_DEN_NOT_NAN: assert property (@(posedge clk) disable iff (rst)
    denorm_flag |-> !invalid); // R4
  AST_INV_IS_NAN: assert property (@(posedge clk) disable iff (rst)
    (invalid && fmt_q == 2'd0) |-> (res_data[14:10] == 5'h1f && res_data[9])); // R5
  AST_HALF_UPPER: assert property (@(posedge clk) disable iff (rst)
    (res_vld && fmt_q == 2'd0) |-> (res_data[63:16] == '0)); // R9
  AST_SINGLE_UPPER: assert property (@(posedge clk) disable iff (rst)
    (res_vld && fmt_q == 2'd1) |-> (res_data[63:32] == '0)); // R9
endmodule

// File: tb/fp_recip_exp_test.sv
module fp_recip_exp_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_vld = 1'b0;
  logic [63:0] op_data = '0;
  logic [1:0]  fmt = 2'd0;
  logic        flush_en = 1'b0;
  logic        dnan_en = 1'b0;
  logic        res_vld;
  logic [63:0] res_data;
  logic        invalid;
  logic        denorm_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_recip_exp uut (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_data(op_data), .fmt(fmt),
    .flush_en(flush_en), .dnan_en(dnan_en), .res_vld(res_vld), .res_data(res_data),
    .invalid(invalid), .denorm_flag(denorm_flag)
  );

  function automatic int ew(input int f); return (f == 0) ? 5 : (f == 1) ? 8 : 11; endfunction
  function automatic int fw(input int f); return (f == 0) ? 10 : (f == 1) ? 23 : 52; endfunction

  function automatic logic [63:0] make_op(input int f, input int kind, input bit s);
    int E = ew(f); int F = fw(f); int W = E + F + 1;
    logic [63:0] fmask = (64'd1 << F) - 1;
    logic [63:0] emax  = (64'd1 << E) - 1;
    logic [63:0] ex, fr, v;
    case (kind)
      0: begin ex = 0;        fr = 0; end
      1: begin ex = 0;        fr = 1; end
      2: begin ex = 0;        fr = fmask; end
      3: begin ex = 1;        fr = 0; end
      4: begin ex = emax >> 1; fr = 64'h5555_5555_5555_5555 & fmask; end
      5: begin ex = emax - 1; fr = fmask; end
      6: begin ex = emax;     fr = 0; end
      7: begin ex = emax;     fr = (64'd1 << (F-1)) | 64'd3; end
      default: begin ex = emax; fr = 64'd5; end
    endcase
    v = (64'(s) << (W-1)) | (ex << F) | fr;
    if (W < 64) v = v | (64'hA5C3_9E17_B24D_6F08 << W);
    return v;
  endfunction

  task automatic expect_of(input int f, input logic [63:0] x, input bit fl, input bit dn,
                           output logic [63:0] r, output bit inv, output bit den);
    int E = ew(f); int F = fw(f); int W = E + F + 1;
    logic [63:0] wmask = (W == 64) ? '1 : ((64'd1 << W) - 1);
    logic [63:0] emax  = (64'd1 << E) - 1;
    logic [63:0] qbit  = 64'd1 << (F-1);
    logic [63:0] xv    = x & wmask;
    logic [63:0] fr    = xv & ((64'd1 << F) - 1);
    logic [63:0] ex    = (xv >> F) & emax;
    logic [63:0] s     = (xv >> (W-1)) & 64'd1;
    inv = 0; den = 0;
    if (ex == emax && fr != 0) begin
      inv = ((fr & qbit) == 0);
      r = dn ? ((emax << F) | qbit) : (xv | qbit);
    end else begin
      den = fl && ex == 0 && fr != 0;
      r = (s << (W-1)) | (((ex == 0) ? emax - 1 : emax - ex) << F);
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic string req_of(input int kind, input bit fl, input bit dn);
    case (kind)
      0: return "R3";
      1, 2: return fl ? "R4" : "R3";
      6: return "R8";
      7: return dn ? "R7" : "R6";
      8: return dn ? "R7" : "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic apply(input int fsel, input int fcode, input int kind, input bit s,
                       input bit fl, input bit dn);
    logic [63:0] x, er; bit ei, ed; string rq;
    x = make_op(fsel, kind, s);
    expect_of(fsel, x, fl, dn, er, ei, ed);
    rq = req_of(kind, fl, dn);
    @(negedge clk);
    op_vld = 1; op_data = x; fmt = 2'(fcode); flush_en = fl; dnan_en = dn;
    @(posedge clk); #1;
    check("R1 valid", 64'(res_vld), 64'd1);
    check({rq, " R9 data"}, res_data, er);
    check({rq, " invalid"}, 64'(invalid), 64'(ei));
    check("R4 denorm", 64'(denorm_flag), 64'(ed));
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset vld", 64'(res_vld), 64'd0);
    check("R1 reset data", res_data, 64'd0);
    check("R10 reset flags", 64'({invalid, denorm_flag}), 64'd0);
    @(negedge clk); rst = 0;
    for (int f = 0; f < 3; f++)
      for (int k = 0; k < 9; k++)
        for (int s = 0; s < 2; s++)
          for (int fl = 0; fl < 2; fl++)
            for (int dn = 0; dn < 2; dn++)
              apply(f, f, k, s[0], fl[0], dn[0]);
    // R9: code 3 acts as double
    for (int k = 0; k < 9; k++) apply(2, 3, k, 1'b1, 1'b1, 1'b0);
    // R10 and R1: idle cycle after an invalid result
    apply(0, 0, 8, 1'b0, 1'b0, 1'b0);
    @(negedge clk); op_vld = 0;
    @(posedge clk); #1;
    check("R1 idle vld", 64'(res_vld), 64'd0);
    check("R10 idle flags", 64'({invalid, denorm_flag}), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule